// File: doc/BRIEF.md
# Predicated Quadword Load-and-Replicate Unit

This unit carries out one vector load instruction at a time. It fetches a single 16-byte quadword from memory and zeroes the elements that the governing predicate marks inactive. It then writes that quadword into every 128-bit segment of a destination vector register whose length is set by a parameter.

The instruction arrives as a 25-bit field word, together with the scalar base value, the scalar offset value and the predicate contents. A flag selects between immediate addressing and register-offset addressing. The unit computes the effective address and derives a 16-bit byte read-enable from the predicate. It issues one request on a valid/ready memory port and waits for a valid response carrying 128 data bits. It then delivers a one-cycle destination write together with a done pulse.

Illegal encodings and a misaligned stack-pointer base complete without touching memory and raise a flag.

Top module: `qrep_load_unit`

## Requirements
- R1: One accepted, non-faulting instruction with at least one active element issues exactly one memory request covering 16 bytes. Element size is 1 << in_instr[24:23] bytes, so the quadword holds 16, 8, 4 or 2 elements.
- R2: With in_imm_form = 1, the request address is in_base plus the sign-extended 4-bit field in_instr[19:16] multiplied by 16.
- R3: With in_imm_form = 0, the request address is in_base plus in_offset multiplied by the element size in bytes.
- R4: in_pred holds one bit per byte. Element e (of size E bytes) is active when in_pred[e*E] is 1. Byte enable bit b is 1 exactly when the element containing byte b is active.
- R5: In the written quadword, every byte of an inactive element is zero and every byte of an active element equals the matching response byte (byte b at bits 8b+7:8b).
- R6: The quadword is copied into each of the VLEN/128 segments of wr_data.
- R7: When in_instr[22:21] is nonzero, undef_flag pulses with done, and no request or destination write occurs.
- R8: wr_idx equals in_instr[4:0]. A base field in_instr[9:5] of 31 denotes the stack pointer. If such a base has in_base[3:0] nonzero, align_flag pulses with done, and no request or write occurs. Undefined encoding takes priority over alignment.
- R9: The request stays valid, with a stable address and enable, until mem_req_ready is high. wr_en and done are high for exactly one cycle, in the cycle after the response is taken.
- R10: in_ready is high only while idle. busy is high from the cycle after acceptance through the write cycle, and in_valid while busy has no effect.
- R11: If no element is active, no request is issued and an all-zero vector is written with done.
- R12: After reset, busy, mem_req_valid, wr_en, done and both flags are low, and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Unit idle, instruction taken when in_valid |
| in_instr | input | 25 | Instruction fields, bits 24:0 |
| in_imm_form | input | 1 | 1 selects immediate addressing, 0 register offset |
| in_base | input | AW | Scalar base value |
| in_offset | input | AW | Scalar offset value |
| in_pred | input | 16 | Predicate, one bit per byte lane |
| busy | output | 1 | Instruction in flight |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_addr | output | AW | Request byte address |
| mem_req_be | output | 16 | Request byte read-enable |
| mem_rsp_valid | input | 1 | Response data valid |
| mem_rsp_data | input | 128 | Response quadword |
| wr_en | output | 1 | Destination write strobe |
| wr_idx | output | 5 | Destination register index |
| wr_data | output | VLEN | Replicated vector |
| done | output | 1 | Instruction completed |
| undef_flag | output | 1 | Undefined encoding, with done |
| align_flag | output | 1 | Misaligned stack-pointer base, with done |

## Verification
The assertions assume that the memory side raises mem_rsp_valid only while a request is outstanding, and only after that request has been accepted. They also assume that the response never arrives in the same cycle as the handshake. The bench memory model honours both assumptions: it drops ready after one handshake, then returns exactly one response on the following cycle.

The bench also stalls ready for two cycles so that request holding is exercised. It offers a second instruction only while the unit is busy, so that the ignored offer can be observed at the ports afterwards.

// File: rtl/qrep_pkg.sv
package qrep_pkg;
  localparam int QBYTES = 16;
  localparam int QBITS  = QBYTES * 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2,
    ST_DONE = 2'd3
  } qrep_state_e;
endpackage

// File: rtl/qrep_addr_gen.sv
module qrep_addr_gen #(
  parameter int AW = 64
) (
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] offset,
  input  logic [3:0]    imm4,
  input  logic          imm_form,
  input  logic [1:0]    esize_log2,
  output logic [AW-1:0] ea
);
  logic [AW-1:0] imm_ext;
  logic [AW-1:0] imm_scaled;
  logic [AW-1:0] off_scaled;

  assign imm_ext    = {{(AW-4){imm4[3]}}, imm4};
  assign imm_scaled = imm_ext << 4;
  assign off_scaled = offset << esize_log2;
  assign ea         = base + (imm_form ? imm_scaled : off_scaled);
endmodule

// File: rtl/qrep_mask_gen.sv
module qrep_mask_gen #(
  parameter int NB = qrep_pkg::QBYTES
) (
  input  logic [NB-1:0] pred,
  input  logic [1:0]    esize_log2,
  output logic [NB-1:0] be,
  output logic          none_active
);
  always_comb begin
    for (int b = 0; b < NB; b++) begin
      int lead;
      lead  = b - (b % (1 << esize_log2));
      be[b] = pred[lead];
    end
  end

  assign none_active = ~|be;
endmodule

// File: rtl/qrep_merge.sv
module qrep_merge #(
  parameter int VLEN = 512
) (
  input  logic [qrep_pkg::QBITS-1:0]  raw,
  input  logic [qrep_pkg::QBYTES-1:0] be,
  output logic [VLEN-1:0]             vec
);
  localparam int NSEG = VLEN / qrep_pkg::QBITS;

  logic [qrep_pkg::QBITS-1:0] quad;

  always_comb begin
    for (int b = 0; b < qrep_pkg::QBYTES; b++)
      quad[b*8 +: 8] = be[b] ? raw[b*8 +: 8] : 8'h00;
  end

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    assign vec[s*qrep_pkg::QBITS +: qrep_pkg::QBITS] = quad;
  end
endmodule

// File: rtl/qrep_load_unit.sv
module qrep_load_unit #(
  parameter int VLEN = 512,
  parameter int AW   = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [24:0]     in_instr,
  input  logic            in_imm_form,
  input  logic [AW-1:0]   in_base,
  input  logic [AW-1:0]   in_offset,
  input  logic [15:0]     in_pred,
  output logic            busy,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [AW-1:0]   mem_req_addr,
  output logic [15:0]     mem_req_be,
  input  logic            mem_rsp_valid,
  input  logic [127:0]    mem_rsp_data,
  output logic            wr_en,
  output logic [4:0]      wr_idx,
  output logic [VLEN-1:0] wr_data,
  output logic            done,
  output logic            undef_flag,
  output logic            align_flag
);
  import qrep_pkg::*;

  localparam logic [4:0] SP_FIELD = 5'd31;

  qrep_state_e st;

  logic [1:0]      esz;
  logic            bad_enc;
  logic            sp_misaligned;
  logic [AW-1:0]   ea;
  logic [15:0]     be;
  logic            none_active;
  logic [VLEN-1:0] merged;
  logic            unused_bits;

  logic [AW-1:0]   ea_q;
  logic [15:0]     be_q;
  logic [4:0]      dst_q;
  logic [VLEN-1:0] wr_data_q;
  logic            done_q, wr_en_q, undef_q, align_q;

  assign esz           = in_instr[24:23];
  assign bad_enc       = |in_instr[22:21];
  assign sp_misaligned = (in_instr[9:5] == SP_FIELD) && (|in_base[3:0]);
  assign unused_bits   = ^{in_instr[20], in_instr[15:10]};

  qrep_addr_gen #(.AW(AW)) addr_i (
    .base       (in_base),
    .offset     (in_offset),
    .imm4       (in_instr[19:16]),
    .imm_form   (in_imm_form),
    .esize_log2 (esz),
    .ea         (ea)
  );

  qrep_mask_gen #(.NB(QBYTES)) mask_i (
    .pred        (in_pred),
    .esize_log2  (esz),
    .be          (be),
    .none_active (none_active)
  );

  qrep_merge #(.VLEN(VLEN)) merge_i (
    .raw (mem_rsp_data),
    .be  (be_q),
    .vec (merged)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      ea_q      <= '0;
      be_q      <= '0;
      dst_q     <= '0;
      wr_data_q <= '0;
      done_q    <= 1'b0;
      wr_en_q   <= 1'b0;
      undef_q   <= 1'b0;
      align_q   <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      wr_en_q <= 1'b0;
      undef_q <= 1'b0;
      align_q <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (in_valid) begin
            ea_q  <= ea;
            be_q  <= be;
            dst_q <= in_instr[4:0];
            if (bad_enc) begin
              st      <= ST_DONE;
              done_q  <= 1'b1;
              undef_q <= 1'b1;
            end else if (sp_misaligned) begin
              st      <= ST_DONE;
              done_q  <= 1'b1;
              align_q <= 1'b1;
            end else if (none_active) begin
              st        <= ST_DONE;
              done_q    <= 1'b1;
              wr_en_q   <= 1'b1;
              wr_data_q <= '0;
            end else begin
              st <= ST_REQ;
            end
          end
        end
        ST_REQ: begin
          if (mem_req_ready) st <= ST_WAIT;
        end
        ST_WAIT: begin
          if (mem_rsp_valid) begin
            st        <= ST_DONE;
            done_q    <= 1'b1;
            wr_en_q   <= 1'b1;
            wr_data_q <= merged;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign in_ready      = (st == ST_IDLE);
  assign busy          = (st != ST_IDLE);
  assign mem_req_valid = (st == ST_REQ);
  assign mem_req_addr  = ea_q;
  assign mem_req_be    = be_q;
  assign wr_en         = wr_en_q;
  assign wr_idx        = dst_q;
  assign wr_data       = wr_data_q;
  assign done          = done_q;
  assign undef_flag    = undef_q;
  assign align_flag    = align_q;
endmodule

// File: rtl/qrep_load_unit_chk.sv
module qrep_load_unit_chk #(
  parameter int VLEN = 512,
  parameter int AW   = 64
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic            in_ready,
  input logic            busy,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic [AW-1:0]   mem_req_addr,
  input logic [15:0]     mem_req_be,
  input logic            mem_rsp_valid,
  input logic            wr_en,
  input logic [VLEN-1:0] wr_data,
  input logic            done,
  input logic            undef_flag,
  input logic            align_flag,
  input logic            waiting
);
  assert_req_hold_R9: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=>
      mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_be));

  assert_write_after_rsp_R9: assert property (@(posedge clk) disable iff (rst)
    waiting && mem_rsp_valid |=> done && wr_en);

  assert_wr_with_done_R9: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> done);

  assert_accept_busy_R10: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> busy);

  assert_done_busy_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> busy);

  assert_req_has_lane_R11: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> (mem_req_be != 16'h0000));

  assert_replicated_R6: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_data[127:0] == wr_data[VLEN-1 -: 128]));

  assert_undef_no_write_R7: assert property (@(posedge clk) disable iff (rst)
    undef_flag |-> done && !wr_en);

  assert_align_no_write_R8: assert property (@(posedge clk) disable iff (rst)
    align_flag |-> done && !wr_en);
endmodule

bind qrep_load_unit qrep_load_unit_chk #(.VLEN(VLEN), .AW(AW)) chk_i (
  .clk           (clk),
  .rst           (rst),
  .in_valid      (in_valid),
  .in_ready      (in_ready),
  .busy          (busy),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .mem_req_be    (mem_req_be),
  .mem_rsp_valid (mem_rsp_valid),
  .wr_en         (wr_en),
  .wr_data       (wr_data),
  .done          (done),
  .undef_flag    (undef_flag),
  .align_flag    (align_flag),
  .waiting       (st == qrep_pkg::ST_WAIT)
);

// File: tb/qrep_load_unit_tb_top.sv
module qrep_load_unit_tb_top;
  localparam int VLEN = 256;
  localparam int AW   = 64;
  localparam int NSEG = VLEN / 128;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            in_valid = 1'b0;
  logic            in_ready;
  logic [24:0]     in_instr = '0;
  logic            in_imm_form = 1'b0;
  logic [AW-1:0]   in_base = '0;
  logic [AW-1:0]   in_offset = '0;
  logic [15:0]     in_pred = '0;
  logic            busy;
  logic            mem_req_valid;
  logic            mem_req_ready = 1'b0;
  logic [AW-1:0]   mem_req_addr;
  logic [15:0]     mem_req_be;
  logic            mem_rsp_valid = 1'b0;
  logic [127:0]    mem_rsp_data = '0;
  logic            wr_en;
  logic [4:0]      wr_idx;
  logic [VLEN-1:0] wr_data;
  logic            done;
  logic            undef_flag;
  logic            align_flag;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  qrep_load_unit #(.VLEN(VLEN), .AW(AW)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_instr(in_instr), .in_imm_form(in_imm_form), .in_base(in_base),
    .in_offset(in_offset), .in_pred(in_pred), .busy(busy),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_req_be(mem_req_be),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .done(done),
    .undef_flag(undef_flag), .align_flag(align_flag)
  );

  task automatic check(input bit ok, input string req,
                       input logic [255:0] act, input logic [255:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [24:0] mk(input int sz, input int cnt,
                                     input logic [4:0] f20, input logic [4:0] bfield,
                                     input logic [4:0] dst);
    logic [24:0] w;
    w = '0;
    w[24:23] = sz[1:0];
    w[22:21] = cnt[1:0];
    w[20:16] = f20;
    w[9:5]   = bfield;
    w[4:0]   = dst;
    return w;
  endfunction

  function automatic logic [15:0] exp_be(input logic [15:0] pred, input int sz);
    int esz;
    logic [15:0] r;
    esz = 1 << sz;
    r = '0;
    for (int e = 0; e < 16 / esz; e++)
      if (pred[e*esz])
        for (int j = 0; j < esz; j++) r[e*esz + j] = 1'b1;
    return r;
  endfunction

  function automatic logic [127:0] mem_word(input logic [63:0] a);
    return {~a, a ^ 64'hA5A5_5A5A_0F0F_F0F0};
  endfunction

  task automatic run_op(input logic [24:0] instr, input bit imm_form,
                        input logic [63:0] base, input logic [63:0] off,
                        input logic [15:0] pred, input bit poke);
    int sz, esz, stall;
    bit exp_undef, exp_align, exp_req, req_seen, got_done;
    logic [63:0] exp_addr, immx;
    logic [15:0] be;
    logic [127:0] q, d;
    logic [VLEN-1:0] exp_vec;
    sz  = int'(instr[24:23]);
    esz = 1 << sz;
    immx = {{60{instr[19]}}, instr[19:16]};
    exp_addr  = imm_form ? base + immx * 64'd16 : base + off * 64'(esz);
    exp_undef = (instr[22:21] != 2'b00);
    exp_align = !exp_undef && (instr[9:5] == 5'd31) && (base[3:0] != 4'h0);
    be        = exp_be(pred, sz);
    exp_req   = !exp_undef && !exp_align && (be != 16'h0);
    d = mem_word(exp_addr);
    for (int b = 0; b < 16; b++) q[b*8 +: 8] = be[b] ? d[b*8 +: 8] : 8'h00;
    for (int s = 0; s < NSEG; s++) exp_vec[s*128 +: 128] = q;

    @(negedge clk);
    in_valid = 1'b1; in_instr = instr; in_imm_form = imm_form;
    in_base = base; in_offset = off; in_pred = pred;
    @(negedge clk);
    in_valid = 1'b0;
    check(busy === 1'b1, "R10 busy after accept", 256'(busy), 256'(1));
    stall = 0; req_seen = 0; got_done = 0;
    for (int cyc = 0; cyc < 40 && !got_done; cyc++) begin
      if (cyc > 0) @(negedge clk);
      mem_rsp_valid = 1'b0;
      in_valid = 1'b0;
      if (done) begin
        got_done = 1;
        check(req_seen == exp_req, "R1 R7 R8 R11 request issued",
              256'(req_seen), 256'(exp_req));
        check(undef_flag === exp_undef, "R7 undef flag", 256'(undef_flag), 256'(exp_undef));
        check(align_flag === exp_align, "R8 align flag", 256'(align_flag), 256'(exp_align));
        check(wr_en === !(exp_undef || exp_align), "R7 R8 write enable",
              256'(wr_en), 256'(!(exp_undef || exp_align)));
        if (!(exp_undef || exp_align)) begin
          check(wr_idx === instr[4:0], "R8 destination index", 256'(wr_idx), 256'(instr[4:0]));
          check(wr_data === exp_vec, "R5 R6 R11 written vector", 256'(wr_data), 256'(exp_vec));
        end
      end else if (mem_req_valid) begin
        if (!req_seen) begin
          req_seen = 1;
          check(mem_req_addr === exp_addr, imm_form ? "R2 immediate address" : "R3 offset address",
                256'(mem_req_addr), 256'(exp_addr));
          check(mem_req_be === be, "R4 byte enable", 256'(mem_req_be), 256'(be));
        end
        if (stall < 2) begin
          if (poke && stall == 0) begin
            in_valid = 1'b1;
            in_instr = mk(0, 0, 5'd3, 5'd1, 5'd9);
            in_imm_form = 1'b1;
            in_pred = 16'hFFFF;
          end
          stall++;
          mem_req_ready = 1'b0;
        end else begin
          mem_req_ready = 1'b1;
        end
      end else if (mem_req_ready) begin
        mem_req_ready = 1'b0;
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = d;
      end
    end
    if (!got_done) check(1'b0, "R9 completion", 256'(0), 256'(1));
    @(negedge clk);
    check(!busy && in_ready && !mem_req_valid && !done, "R10 idle after write",
          256'({busy, in_ready, mem_req_valid, done}), 256'(4'b0100));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] preds [6];
    logic [63:0] offs [5];
    preds[0] = 16'hFFFF; preds[1] = 16'h0001; preds[2] = 16'h8100;
    preds[3] = 16'h5555; preds[4] = 16'h0F0F; preds[5] = 16'h0110;
    offs[0] = 64'd0; offs[1] = 64'd1; offs[2] = 64'd5;
    offs[3] = 64'hFFFF_FFFF_FFFF_FFFD; offs[4] = 64'd100;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    check(!busy && in_ready && !mem_req_valid && !wr_en && !done && !undef_flag && !align_flag,
          "R12 reset state",
          256'({busy, in_ready, mem_req_valid, wr_en, done, undef_flag, align_flag}),
          256'(7'b0100000));

    // R2 immediate sweep over all sizes and immediates
    for (int sz = 0; sz < 4; sz++)
      for (int i = -8; i < 8; i++) begin
        logic [15:0] p;
        p = 16'hA5C3 >> (i + 8);
        p = p | (16'hA5C3 << (8 - i));
        run_op(mk(sz, 0, {1'b0, 4'(i)}, 5'd2, 5'(i + 8 + sz)), 1'b1,
               64'h0000_1234_5678_9A00 + 64'(sz * 7), 64'd0, p, 1'b0);
      end

    // R3 R4 R5 register-offset sweep over sizes, offsets and predicates
    for (int sz = 0; sz < 4; sz++)
      for (int k = 0; k < 5; k++)
        for (int m = 0; m < 6; m++)
          run_op(mk(sz, 0, 5'd7, 5'd4, 5'(k * 6 + m)), 1'b0,
                 64'h0000_0000_4000_0010, offs[k], preds[m], 1'b0);

    // R7 undefined count field values
    for (int c = 1; c < 4; c++)
      run_op(mk(c, c, 5'd1, 5'd31, 5'd3), 1'b1, 64'h1001, 64'd0, 16'hFFFF, 1'b0);

    // R8 stack-pointer base: misaligned faults, aligned runs
    run_op(mk(2, 0, 5'd2, 5'd31, 5'd12), 1'b1, 64'h0000_0000_0000_8008, 64'd0, 16'hFFFF, 1'b0);
    run_op(mk(1, 0, 5'd2, 5'd31, 5'd13), 1'b1, 64'h0000_0000_0000_8000, 64'd0, 16'h3333, 1'b0);
    // R8 misaligned but not stack pointer base runs normally
    run_op(mk(0, 0, 5'd2, 5'd30, 5'd14), 1'b1, 64'h0000_0000_0000_8008, 64'd0, 16'hF0F0, 1'b0);

    // R11 all-inactive predicate for every size
    for (int sz = 0; sz < 4; sz++)
      run_op(mk(sz, 0, 5'd0, 5'd5, 5'd20 + 5'(sz)), 1'b0, 64'h2000, 64'd3, 16'h0000, 1'b0);

    // R10 offer while busy is ignored
    run_op(mk(3, 0, 5'd15, 5'd6, 5'd25), 1'b1, 64'h9000, 64'd0, 16'h0101, 1'b1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule